// File: doc/BRIEF.md
# Multiplexed Pin Bank Controller

This block governs one bank of general-purpose pins. Each pin is handed to one of three owners: the controller itself, which drives the pin from its own output-data and output-enable bits, or one of two internal peripheral functions, A or B. For every pin the block also keeps a pull-up enable and an open-drain mode, and it reports the live level of every pad whichever function owns it.

Software reaches the block over a simple synchronous word-addressed port. Every configuration field has three addresses: writing ones to the set address sets those bits, writing ones to the clear address clears those bits, and the status address reads the field back. A zero bit in a write never changes its pin. Because output data can be written while the output is still off, a pin can be switched to drive without a glitch. The pads are modelled as separate output, output-enable, pull-up and input signals.

Top module: `pio_bank_ctrl`

## Requirements
- R1: After reset every pin is owned by the controller, output data and output enable are 0, pull-ups are on, open-drain is off and peripheral A is selected (peripheral-select status reads 0).
- R2: Field f (own=0, select-B=1, output data=2, output enable=3, pull-up=4, open-drain=5) has its set address at word 3f; a write there sets exactly the bits that are 1 in the write data and leaves the others unchanged.
- R3: A write to the clear address of field f, word 3f+1, clears exactly the bits that are 1 in the write data and leaves the others unchanged.
- R4: A pin whose own bit is 1 drives pad_out from its output-data bit and pad_oe from its output-enable bit (when open-drain is off).
- R5: A pin whose own bit is 0 takes output and output enable from peripheral B when its select-B bit is 1, otherwise from peripheral A.
- R6: Output data written while output enable is 0 leaves pad_oe at 0; a later output-enable write drives the preset value at once.
- R7: With open-drain on, pad_out is 0 and pad_oe is 1 only when the selected source enables the output and drives 0; a 1 floats the pad. This applies to every owner.
- R8: pad_pu follows the pull-up field for every pin regardless of owner.
- R9: Reading word 18 returns pad_in for all pins, whoever owns them.
- R10: Reading a set or clear address, or any word above 18, returns 0; writes to status words (3f+2) and to word 18 change nothing.
- R11: Read data appears on bus_rdata on the clock edge that samples bus_rd and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Registered read data |
| pa_out | input | 32 | Peripheral A output value per pin |
| pa_oe | input | 32 | Peripheral A output enable per pin |
| pb_out | input | 32 | Peripheral B output value per pin |
| pb_oe | input | 32 | Peripheral B output enable per pin |
| pad_in | input | 32 | Sampled pad level per pin |
| pad_out | output | 32 | Value driven to each pad |
| pad_oe | output | 32 | Drive enable to each pad |
| pad_pu | output | 32 | Pull-up enable to each pad |

## Verification
A wrong configuration bit shows on the pad outputs in the very cycle after the write that caused it, because the pad mux is combinational from the field registers; the bench therefore compares all three pad vectors after every write against a model. A corrupted bit that is masked at the pads (for instance output data on a pin owned by a peripheral) only shows on a status read, one cycle after the read strobe, so status words are read back at intervals during the random sequence and at the end.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PIN_COUNT   = 32;
    localparam int ADDR_W      = 5;
    localparam int FIELD_COUNT = 6;

    // Field index; address of a field: set 3f, clear 3f+1, status 3f+2
    localparam int F_OWN  = 0;
    localparam int F_SELB = 1;
    localparam int F_DOUT = 2;
    localparam int F_OE   = 3;
    localparam int F_PU   = 4;
    localparam int F_OD   = 5;

    localparam int LEVEL_WORD = 3 * FIELD_COUNT;

    function automatic int set_word(input int f);
        return 3 * f;
    endfunction

    function automatic int clr_word(input int f);
        return 3 * f + 1;
    endfunction

    function automatic int stat_word(input int f);
        return 3 * f + 2;
    endfunction
endpackage

// File: rtl/pio_field_reg.sv
module pio_field_reg #(
    parameter int            WIDTH = 32,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } field_state_t;

    field_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en) st_d.bits = st_q.bits | wdata;
        if (clr_en) st_d.bits = st_d.bits & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.bits <= RST_VAL;
        else        st_q <= st_d;
    end

    assign q = st_q.bits;

    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en) |=> ((q & $past(wdata)) == $past(wdata))) else $error("set failed"); // R2
    AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((q & $past(wdata)) == '0)) else $error("clear failed"); // R3
    AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en || clr_en) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))) else $error("zero bit changed"); // R2
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(q)) else $error("field moved without write"); // R10
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
    parameter int N = 32
) (
    input  logic [N-1:0] own,
    input  logic [N-1:0] selb,
    input  logic [N-1:0] dout,
    input  logic [N-1:0] oe,
    input  logic [N-1:0] od,
    input  logic [N-1:0] pa_out,
    input  logic [N-1:0] pa_oe,
    input  logic [N-1:0] pb_out,
    input  logic [N-1:0] pb_oe,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic src_out, src_oe;

        always_comb begin
            if (own[i]) begin
                src_out = dout[i];
                src_oe  = oe[i];
            end else if (selb[i]) begin
                src_out = pb_out[i];
                src_oe  = pb_oe[i];
            end else begin
                src_out = pa_out[i];
                src_oe  = pa_oe[i];
            end
            if (od[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = src_oe & ~src_out;
            end else begin
                pad_out[i] = src_out;
                pad_oe[i]  = src_oe;
            end
        end
    end
endmodule

// File: rtl/pio_bank_ctrl.sv
module pio_bank_ctrl
    import pio_pkg::*;
#(
    parameter int NPIN = PIN_COUNT,
    parameter int AW   = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pa_out,
    input  logic [NPIN-1:0] pa_oe,
    input  logic [NPIN-1:0] pb_out,
    input  logic [NPIN-1:0] pb_oe,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pu
);
    logic [NPIN-1:0] field_q [FIELD_COUNT];

    for (genvar f = 0; f < FIELD_COUNT; f++) begin : g_field
        localparam logic [NPIN-1:0] RST =
            (f == F_OWN || f == F_PU) ? {NPIN{1'b1}} : {NPIN{1'b0}};
        logic hit_set, hit_clr;
        assign hit_set = bus_wr && (bus_addr == AW'(set_word(f)));
        assign hit_clr = bus_wr && (bus_addr == AW'(clr_word(f)));

        pio_field_reg #(.WIDTH(NPIN), .RST_VAL(RST)) u_field (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (hit_set),
            .clr_en (hit_clr),
            .wdata  (bus_wdata),
            .q      (field_q[f])
        );
    end

    pio_pad_mux #(.N(NPIN)) u_mux (
        .own     (field_q[F_OWN]),
        .selb    (field_q[F_SELB]),
        .dout    (field_q[F_DOUT]),
        .oe      (field_q[F_OE]),
        .od      (field_q[F_OD]),
        .pa_out  (pa_out),
        .pa_oe   (pa_oe),
        .pb_out  (pb_out),
        .pb_oe   (pb_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign pad_pu = field_q[F_PU];

    typedef struct packed {
        logic [NPIN-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    logic [NPIN-1:0] rd_sel;

    always_comb begin
        rd_sel = '0;
        for (int f = 0; f < FIELD_COUNT; f++) begin
            if (bus_addr == AW'(stat_word(f))) rd_sel = field_q[f];
        end
        if (bus_addr == AW'(LEVEL_WORD)) rd_sel = pad_in;
        rd_d = rd_q;
        if (bus_rd) rd_d.rdata = rd_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((field_q[F_OD] & pad_oe & pad_out) == '0)) else $error("open-drain drove high"); // R7
    AST_OWNED_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & field_q[F_OWN] & ~field_q[F_OD]) ==
         (field_q[F_OE] & field_q[F_OWN] & ~field_q[F_OD]))) else $error("owned pin enable wrong"); // R4
    AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr > AW'(LEVEL_WORD))) |=> (bus_rdata == '0)) else $error("unmapped read nonzero"); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)) else $error("read data moved"); // R11
endmodule

// File: tb/tb_pio_bank_ctrl.sv
module tb_pio_bank_ctrl;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr, bus_rd;
    logic [4:0]    bus_addr;
    logic [N-1:0]  bus_wdata, bus_rdata;
    logic [N-1:0]  pa_out, pa_oe, pb_out, pb_oe, pad_in;
    logic [N-1:0]  pad_out, pad_oe, pad_pu;

    always #2 clk = ~clk;

    pio_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [N-1:0] m [6];

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] exp_pad(input logic [N-1:0] pao, pae, pbo, pbe);
        logic [N-1:0] o, e;
        for (int i = 0; i < N; i++) begin
            logic so, se;
            if (m[0][i])      begin so = m[2][i]; se = m[3][i]; end
            else if (m[1][i]) begin so = pbo[i];  se = pbe[i];  end
            else              begin so = pao[i];  se = pae[i];  end
            if (m[5][i]) begin o[i] = 1'b0; e[i] = se & ~so; end
            else         begin o[i] = so;   e[i] = se;       end
        end
        return {o, e};
    endfunction

    task automatic wr(input int addr, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(addr); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (addr < 18) begin
            if (addr % 3 == 0) m[addr/3] = m[addr/3] | d;
            else if (addr % 3 == 1) m[addr/3] = m[addr/3] & ~d;
        end
    endtask

    task automatic rd(input int addr, output logic [N-1:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 5'(addr);
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic check_pads(input string req);
        logic [2*N-1:0] ep;
        ep = exp_pad(pa_out, pa_oe, pb_out, pb_oe);
        chk({req, " pad_out"}, pad_out, ep[2*N-1:N]);
        chk({req, " pad_oe"},  pad_oe,  ep[N-1:0]);
        chk({"R8 ", req, " pad_pu"}, pad_pu, m[4]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd1234));
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        pa_out = '0; pa_oe = '0; pb_out = '0; pb_oe = '0; pad_in = '0;
        m[0] = '1; m[1] = '0; m[2] = '0; m[3] = '0; m[4] = '1; m[5] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int f = 0; f < 6; f++) begin
            rd(3*f + 2, v);
            chk($sformatf("R1 reset field %0d", f), v, m[f]);
        end
        check_pads("R1 reset");

        // R6 preset output data before enabling
        wr(6, 32'h0000_0020);
        chk("R6 preset oe off", pad_oe, 32'h0);
        wr(9, 32'h0000_0020);
        chk("R6 enable drives preset", pad_out & pad_oe, 32'h0000_0020);

        // R2/R3 zero bits leave pins unchanged
        wr(6, 32'hF0F0_0000);
        rd(8, v); chk("R2 set only ones", v, 32'hF0F0_0020);
        wr(7, 32'h3000_0020);
        rd(8, v); chk("R3 clear only ones", v, 32'hC0F0_0000);

        // R5 peripheral A then B
        pa_out = 32'hAAAA_5555; pa_oe = 32'h0F0F_F0F0;
        pb_out = 32'h1234_5678; pb_oe = 32'hFFFF_0000;
        wr(1, 32'hFFFF_FFFF);
        check_pads("R5 periph A");
        wr(3, 32'h00FF_FF00);
        check_pads("R5 periph B");

        // R7 open drain on peripherals
        wr(15, 32'hFFFF_FFFF);
        check_pads("R7 open drain");
        chk("R7 no drive high", pad_out, 32'h0);

        // R9 level readback with peripheral ownership
        pad_in = 32'hDEAD_BEEF;
        rd(18, v); chk("R9 level", v, 32'hDEAD_BEEF);

        // R10 strobe/unmapped reads zero, status writes ignored
        rd(0, v);  chk("R10 set addr reads 0", v, 32'h0);
        rd(13, v); chk("R10 clr addr reads 0", v, 32'h0);
        rd(31, v); chk("R10 unmapped reads 0", v, 32'h0);
        wr(2, 32'hFFFF_FFFF);
        wr(18, 32'hFFFF_FFFF);
        rd(2, v);  chk("R10 status write ignored", v, m[0]);
        check_pads("R10 after status write");

        // R11 read data holds
        rd(14, v);
        repeat (3) @(negedge clk);
        chk("R11 hold", bus_rdata, m[4]);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int f, a;
            pa_out = $urandom; pa_oe = $urandom;
            pb_out = $urandom; pb_oe = $urandom;
            pad_in = $urandom;
            f = $urandom_range(0, 5);
            a = 3*f + (($urandom % 2 == 0) ? 0 : 1);
            wr(a, $urandom);
            check_pads((a % 3 == 0) ? "R2 R4 R5 R7 random" : "R3 R4 R5 R7 random");
            if (it % 8 == 0) begin
                int sf;
                sf = $urandom_range(0, 5);
                rd(3*sf + 2, v);
                chk($sformatf("R2 R3 status field %0d", sf), v, m[sf]);
                rd(18, v);
                chk("R9 random level", v, pad_in);
            end
        end
        for (int f = 0; f < 6; f++) begin
            rd(3*f + 2, v);
            chk($sformatf("R2 R3 final field %0d", f), v, m[f]);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule